// File: doc/BRIEF.md
# Register File with Rename Tags

This block is the architectural register file of a dynamically scheduled core. Besides its data word, every register carries a producer tag. The tag names the execution station whose result the register is still waiting for. A tag of zero means nothing is outstanding and the stored word is current.

Two combinational read ports serve the issue stage. For each source operand, a read hands back one of two things. If the register is current, it returns the data word. If the register is pending, it returns the producer tag, so the consumer can watch the result bus for that tag. A rename port lets a newly issued instruction claim its destination register. The claim overwrites any older pending tag, so later writers always take precedence.

A snoop port watches the result broadcast bus. A broadcast updates only those registers whose stored tag equals the broadcast tag, and it then marks them current. A result from an older, superseded producer therefore never lands in the register. Write-after-write ordering is handled this way without stalling issue.

Top module: `tag_regfile`

## Requirements
- R1: Each of the two read ports is combinational; for a register whose tag is zero it reports ready=1, tag output 0 and the stored data word.
- R2: A rename with a nonzero tag sets the destination register's tag to that tag from the next cycle on, replacing any tag that was already pending.
- R3: A broadcast with a nonzero tag writes its data into every register whose stored tag equals that tag and clears that tag to zero; a broadcast whose tag does not match a register's current tag (for example a superseded producer) leaves that register pending and its tag unchanged.
- R4: A read of a register with a nonzero tag that is not being broadcast in that cycle reports ready=0 and presents the stored tag on the tag output; a ready read always presents tag 0.
- R5: When a rename and a matching broadcast target the same register in the same cycle, the rename takes precedence and the register stays pending on the new tag.
- R6: When a read hits a register whose tag matches the broadcast in the same cycle, the read reports ready=1 with the broadcast data.
- R7: With the zero-register option enabled (default), register 0 ignores renames and always reads ready=1 with data 0.
- R8: A synchronous active-high reset clears every tag and every data word to zero, so all registers read ready=1 with data 0.
- R9: A rename carrying tag 0 and a broadcast carrying tag 0 have no effect on any register.
- R10: A read of a register in the same cycle it is renamed returns the state from before the rename.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rdAddrA | input | log2(NUM_REGS) | Read port A register index |
| rdReadyA | output | 1 | Port A operand is available |
| rdValA | output | DATA_W | Port A data word (meaningful when ready) |
| rdTagA | output | TAG_W | Port A producer tag (0 when ready) |
| rdAddrB | input | log2(NUM_REGS) | Read port B register index |
| rdReadyB | output | 1 | Port B operand is available |
| rdValB | output | DATA_W | Port B data word (meaningful when ready) |
| rdTagB | output | TAG_W | Port B producer tag (0 when ready) |
| renValid | input | 1 | Rename request this cycle |
| renAddr | input | log2(NUM_REGS) | Destination register being claimed |
| renTag | input | TAG_W | Tag of the new producer |
| bcValid | input | 1 | Result broadcast present this cycle |
| bcTag | input | TAG_W | Tag of the producer broadcasting |
| bcData | input | DATA_W | Broadcast result data |

## Verification
A corrupted tag shows up on the very next read of that register. It may appear as a wrong ready flag, as a wrong tag that would make the consumer wait on the wrong producer, or as a missed bypass when that producer broadcasts. A wrong data word stays hidden while the register is pending. It becomes visible in the first cycle a read finds the register current. The bench therefore sweeps every register through both read ports after each kind of update. It then runs a long mixed stream of renames, broadcasts and reads, including tag zero, collisions and stale producers, against a bench-side model of the tag rules.

// File: rtl/tag_regfile_pkg.sv
package tag_regfile_pkg;
  // Per-read-port decision handed from control to datapath.
  typedef struct packed {
    logic ready;   // operand usable this cycle
    logic bypass;  // take data from the broadcast bus
  } rdSel_t;
endpackage

// File: rtl/tag_regfile_ctrl.sv
module tag_regfile_ctrl
  import tag_regfile_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 3,
  parameter bit ZERO_REG = 1'b1,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        renValid,
  input  logic [AW-1:0]               renAddr,
  input  logic [TAG_W-1:0]            renTag,
  input  logic                        bcValid,
  input  logic [TAG_W-1:0]            bcTag,
  input  logic [1:0][AW-1:0]          rdAddr,
  output logic [NUM_REGS-1:0]         valWe,
  output rdSel_t [1:0]                rdSel,
  output logic [1:0][TAG_W-1:0]       rdTag
);
  logic [NUM_REGS-1:0][TAG_W-1:0] tagVec;
  logic bcLive;
  logic renLive;

  assign bcLive  = bcValid && (bcTag != '0);
  assign renLive = renValid && (renTag != '0) && !(ZERO_REG && renAddr == '0);

  // Per-register producer tag: newest rename wins over a matching broadcast.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_tag
    logic [TAG_W-1:0] tagR;
    logic hitBc;
    logic hitRen;
    assign hitBc    = bcLive && (tagR == bcTag);
    assign hitRen   = renLive && (renAddr == AW'(i));
    assign valWe[i] = hitBc && !hitRen;
    always_ff @(posedge clk) begin
      if (rst)         tagR <= '0;
      else if (hitRen) tagR <= renTag;
      else if (hitBc)  tagR <= '0;
    end
    assign tagVec[i] = tagR;
  end

  // Read decisions, with same-cycle broadcast bypass.
  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [TAG_W-1:0] curTag;
    logic isZero;
    logic byp;
    assign curTag = tagVec[rdAddr[p]];
    assign isZero = ZERO_REG && (rdAddr[p] == '0);
    assign byp    = bcLive && !isZero && (curTag == bcTag);
    assign rdSel[p].bypass = byp;
    assign rdSel[p].ready  = isZero || (curTag == '0) || byp;
    assign rdTag[p] = rdSel[p].ready ? '0 : curTag;
  end
endmodule

// File: rtl/tag_regfile_data.sv
module tag_regfile_data
  import tag_regfile_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_REGS-1:0]         valWe,
  input  logic [DATA_W-1:0]           bcData,
  input  logic [1:0][AW-1:0]          rdAddr,
  input  rdSel_t [1:0]                rdSel,
  output logic [1:0][DATA_W-1:0]      rdVal
);
  logic [NUM_REGS-1:0][DATA_W-1:0] valVec;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_val
    logic [DATA_W-1:0] valR;
    always_ff @(posedge clk) begin
      if (rst)           valR <= '0;
      else if (valWe[i]) valR <= bcData;
    end
    assign valVec[i] = valR;
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rdVal[p] = rdSel[p].bypass ? bcData : valVec[rdAddr[p]];
  end
endmodule

// File: rtl/tag_regfile.sv
module tag_regfile
  import tag_regfile_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 3,
  parameter bit ZERO_REG = 1'b1,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     rdAddrA,
  output logic              rdReadyA,
  output logic [DATA_W-1:0] rdValA,
  output logic [TAG_W-1:0]  rdTagA,
  input  logic [AW-1:0]     rdAddrB,
  output logic              rdReadyB,
  output logic [DATA_W-1:0] rdValB,
  output logic [TAG_W-1:0]  rdTagB,
  input  logic              renValid,
  input  logic [AW-1:0]     renAddr,
  input  logic [TAG_W-1:0]  renTag,
  input  logic              bcValid,
  input  logic [TAG_W-1:0]  bcTag,
  input  logic [DATA_W-1:0] bcData
);
  logic [1:0][AW-1:0]     rdAddr;
  logic [NUM_REGS-1:0]    valWe;
  rdSel_t [1:0]           rdSel;
  logic [1:0][TAG_W-1:0]  rdTag;
  logic [1:0][DATA_W-1:0] rdVal;

  assign rdAddr = {rdAddrB, rdAddrA};

  tag_regfile_ctrl #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .ZERO_REG(ZERO_REG)) ctrl_i (
    .clk(clk), .rst(rst),
    .renValid(renValid), .renAddr(renAddr), .renTag(renTag),
    .bcValid(bcValid), .bcTag(bcTag),
    .rdAddr(rdAddr), .valWe(valWe), .rdSel(rdSel), .rdTag(rdTag)
  );

  tag_regfile_data #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) data_i (
    .clk(clk), .rst(rst), .valWe(valWe), .bcData(bcData),
    .rdAddr(rdAddr), .rdSel(rdSel), .rdVal(rdVal)
  );

  assign rdReadyA = rdSel[0].ready;
  assign rdReadyB = rdSel[1].ready;
  assign rdValA   = rdVal[0];
  assign rdValB   = rdVal[1];
  assign rdTagA   = rdTag[0];
  assign rdTagB   = rdTag[1];
endmodule

// File: rtl/tag_regfile_chk.sv
module tag_regfile_chk #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 3,
  parameter bit ZERO_REG = 1'b1,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst,
  input logic [AW-1:0]     rdAddrA,
  input logic              rdReadyA,
  input logic [DATA_W-1:0] rdValA,
  input logic [TAG_W-1:0]  rdTagA,
  input logic [AW-1:0]     rdAddrB,
  input logic              rdReadyB,
  input logic [DATA_W-1:0] rdValB,
  input logic              renValid,
  input logic [AW-1:0]     renAddr,
  input logic [TAG_W-1:0]  renTag,
  input logic              bcValid,
  input logic [TAG_W-1:0]  bcTag,
  input logic [DATA_W-1:0] bcData
);
  // R8: first cycle after reset every register reads ready with zero data.
  p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rdReadyA && rdReadyB && rdValA == '0 && rdValB == '0));

  // R4: ready and a nonzero tag never appear together, and a wait always names a producer.
  p_tag_ready_r4: assert property (@(posedge clk) disable iff (rst)
    rdReadyA == (rdTagA == '0));

  // R7: hardwired zero register.
  p_zero_reg_r7: assert property (@(posedge clk) disable iff (rst)
    (ZERO_REG && rdAddrA == '0) |-> (rdReadyA && rdValA == '0));

  // R2 / R5: a live rename leaves the register pending on the new tag next cycle.
  p_rename_pending_r2: assert property (@(posedge clk) disable iff (rst)
    (renValid && renTag != '0 && !(ZERO_REG && renAddr == '0)) |=>
      (rdAddrA != $past(renAddr) || (bcValid && bcTag == $past(renTag)) ||
       (!rdReadyA && rdTagA == $past(renTag))));

  // R6: a waiting read becomes ready with the bus data when its producer broadcasts.
  p_bypass_r6: assert property (@(posedge clk) disable iff (rst)
    (!rdReadyA ##1 (bcValid && bcTag == $past(rdTagA) && rdAddrA == $past(rdAddrA) &&
                    !($past(renValid) && $past(renAddr) == rdAddrA)))
      |-> (rdReadyA && rdValA == bcData));
endmodule

bind tag_regfile tag_regfile_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .ZERO_REG(ZERO_REG)
) chk_i (
  .clk(clk), .rst(rst),
  .rdAddrA(rdAddrA), .rdReadyA(rdReadyA), .rdValA(rdValA), .rdTagA(rdTagA),
  .rdAddrB(rdAddrB), .rdReadyB(rdReadyB), .rdValB(rdValB),
  .renValid(renValid), .renAddr(renAddr), .renTag(renTag),
  .bcValid(bcValid), .bcTag(bcTag), .bcData(bcData)
);

// File: tb/tag_regfile_tb_top.sv
module tag_regfile_tb_top;
  localparam int NR = 8;
  localparam int DW = 16;
  localparam int TW = 3;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] rdAddrA = '0, rdAddrB = '0, renAddr = '0;
  logic rdReadyA, rdReadyB;
  logic [DW-1:0] rdValA, rdValB, bcData = '0;
  logic [TW-1:0] rdTagA, rdTagB, renTag = '0, bcTag = '0;
  logic renValid = 1'b0, bcValid = 1'b0;

  int checks = 0;
  int failures = 0;
  int mTag [NR];
  logic [DW-1:0] mVal [NR];
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;

  tag_regfile #(.NUM_REGS(NR), .DATA_W(DW), .TAG_W(TW), .ZERO_REG(1'b1)) dut_i (
    .clk(clk), .rst(rst),
    .rdAddrA(rdAddrA), .rdReadyA(rdReadyA), .rdValA(rdValA), .rdTagA(rdTagA),
    .rdAddrB(rdAddrB), .rdReadyB(rdReadyB), .rdValB(rdValB), .rdTagB(rdTagB),
    .renValid(renValid), .renAddr(renAddr), .renTag(renTag),
    .bcValid(bcValid), .bcTag(bcTag), .bcData(bcData)
  );

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [31:0] nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  // Compare one read port against the model; label picked by case unless given.
  task automatic checkPort(string port, int a, logic rdy, logic [DW-1:0] val,
                           logic [TW-1:0] tg, string label);
    logic eRdy;
    logic [DW-1:0] eVal;
    int eTag;
    string lab;
    if (a == 0) begin
      eRdy = 1'b1; eVal = '0; eTag = 0; lab = "R7";
    end else if (mTag[a] == 0) begin
      eRdy = 1'b1; eVal = mVal[a]; eTag = 0; lab = "R1";
    end else if (bcValid && bcTag != 0 && int'(bcTag) == mTag[a]) begin
      eRdy = 1'b1; eVal = bcData; eTag = 0; lab = "R6";
    end else begin
      eRdy = 1'b0; eVal = val; eTag = mTag[a]; lab = "R4";
    end
    if (label != "") lab = label;
    checks++;
    if (rdy !== eRdy || val !== eVal || int'(tg) !== eTag) begin
      failures++;
      $display("FAIL %s port %s reg %0d: actual rdy=%0b val=%h tag=%0d expected rdy=%0b val=%h tag=%0d",
               lab, port, a, rdy, val, tg, eRdy, eVal, eTag);
    end
  endtask

  // One cycle: drive, check combinational reads, clock, update model.
  task automatic step(logic rv, int ra, int rt, logic bv, int bt, logic [DW-1:0] bd,
                      int a, int b, string label);
    renValid = rv; renAddr = AW'(ra); renTag = TW'(rt);
    bcValid = bv; bcTag = TW'(bt); bcData = bd;
    rdAddrA = AW'(a); rdAddrB = AW'(b);
    #5;
    checkPort("A", a, rdReadyA, rdValA, rdTagA, label);
    checkPort("B", b, rdReadyB, rdValB, rdTagB, label);
    @(posedge clk);
    for (int i = 0; i < NR; i++) begin
      if (rv && rt != 0 && ra == i && i != 0) mTag[i] = rt;
      else if (bv && bt != 0 && mTag[i] == bt) begin
        mTag[i] = 0; mVal[i] = bd;
      end
    end
    #1;
  endtask

  task automatic sweep(string label);
    for (int i = 0; i < NR; i++) step(1'b0, 0, 0, 1'b0, 0, '0, i, NR - 1 - i, label);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) begin mTag[i] = 0; mVal[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R8: everything ready with zero data after reset.
    sweep("R8");

    // R2 then R6 then R3: fill each register through rename and broadcast.
    for (int i = 1; i < NR; i++) begin
      step(1'b1, i, i, 1'b0, 0, '0, i, i, "R10");
      step(1'b0, 0, 0, 1'b0, 0, '0, i, i, "R2");
      step(1'b0, 0, 0, 1'b1, i, DW'(16'h100 + i), i, 0, "R6");
      step(1'b0, 0, 0, 1'b0, 0, '0, i, i, "R3");
    end
    sweep("R1");

    // R2/R3: WAW, stale producer 5 superseded by 6 on r3.
    step(1'b1, 3, 5, 1'b0, 0, '0, 3, 3, "R10");
    step(1'b1, 3, 6, 1'b0, 0, '0, 3, 3, "R4");
    step(1'b0, 0, 0, 1'b1, 5, 16'hDEAD, 3, 3, "R3");
    step(1'b0, 0, 0, 1'b0, 0, '0, 3, 3, "R3");
    step(1'b0, 0, 0, 1'b1, 6, 16'h6006, 3, 3, "R6");
    step(1'b0, 0, 0, 1'b0, 0, '0, 3, 3, "R3");

    // R5: rename and matching broadcast collide on r4.
    step(1'b1, 4, 2, 1'b0, 0, '0, 4, 4, "R10");
    step(1'b1, 4, 3, 1'b1, 2, 16'hBEEF, 5, 5, "R5");
    step(1'b0, 0, 0, 1'b0, 0, '0, 4, 4, "R5");
    step(1'b0, 0, 0, 1'b1, 3, 16'h3333, 4, 4, "R6");

    // R9: tag zero rename and broadcast are ignored.
    step(1'b1, 5, 0, 1'b0, 0, '0, 5, 5, "R9");
    step(1'b0, 0, 0, 1'b1, 0, 16'h0BAD, 5, 5, "R9");
    sweep("R9");

    // R7: renaming register 0 has no effect.
    step(1'b1, 0, 4, 1'b0, 0, '0, 0, 0, "R7");
    step(1'b0, 0, 0, 1'b1, 4, 16'h4444, 0, 0, "R7");
    sweep("");

    // Mixed stream.
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = nextRand();
      step(r[0], int'(r[3:1]), int'(r[6:4]), r[7] | r[8], int'(r[11:9]),
           r[27:12], int'(r[30:28]), int'(r[14:12]), "");
    end
    sweep("");

    // R8: reset in the middle of activity clears all.
    step(1'b1, 2, 7, 1'b0, 0, '0, 2, 2, "");
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    for (int i = 0; i < NR; i++) begin mTag[i] = 0; mVal[i] = '0; end
    sweep("R8");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule